// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a two-stage watchdog. A free-running prescaler counts clock cycles and produces one tick per period of `BASE_PERIOD` cycles. A 12-bit main counter advances on each tick. When the main counter reaches the programmed threshold, the block emits a one-cycle overflow pulse and the main counter starts again from zero. The time to overflow is therefore the threshold times one prescaler period. A threshold of 1 gives the shortest interval.

Software keeps the watchdog from firing with two writes on a simple write port. One write clears the prescaler, and it acts only when the 32-bit value 0x00000055 is written to the clear address with a longword access. The other write stores a new threshold, which also clears the main counter. Software usually issues both writes together as a refresh. A threshold of zero switches overflow generation off. The block has no stream data path, so every pin is a plain control or status signal with no handshake.

Top module: `kcw_top`

## Requirements
- R1: During synchronous reset (`rst` high) both counters go to 0, the threshold goes to 4095 and `ovf_pulse` goes low.
- R2: The prescaler `base_count` increments by one on every clock and wraps from `BASE_PERIOD-1` to 0.
- R3: `main_count` changes only when the prescaler wraps, where it increments by one, or when the threshold register is written.
- R4: A write with `wr_addr` = 0x04, `wr_size` = 2'b10 (longword) and `wr_data` = 0x00000055 sets `base_count` to 0 on the next clock edge, and that edge produces no tick.
- R5: A write to address 0x04 with any other data value, or with size 2'b00 (byte) or 2'b01 (word), has no effect. The same holds for a write to any address other than 0x00 and 0x04. In these cases `base_count` keeps counting normally.
- R6: A write of any size to address 0x00 loads `wr_data[11:0]` into the threshold (`setting`) and clears `main_count` to 0 on the same edge.
- R7: With threshold S > 0, `main_count` returns to 0 on the tick that would make it equal S. On that same edge `ovf_pulse` rises for exactly one cycle. Overflows then repeat every S × `BASE_PERIOD` cycles.
- R8: A threshold of 1 gives the minimum overflow interval of one prescaler period.
- R9: With a threshold of 0, `ovf_pulse` never rises and `main_count` stays at 0.
- R10: If the prescaler clear is written more often than once per `BASE_PERIOD` cycles, the main counter never advances and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write address: 0x00 is the threshold, 0x04 is the prescaler clear |
| wr_size | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| wr_data | input | 32 | Write data |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| base_count | output | BASE_W | Current prescaler value |
| main_count | output | 12 | Current main counter value |
| setting | output | 12 | Current overflow threshold |

## Verification
The assertions assume that `BASE_PERIOD` is at least 2. This guarantees a gap of at least one clock between two overflow pulses. They also assume the write fields carry known values whenever `wr_en` is high. The bench drives all inputs on falling edges and issues at most one write per cycle. It keeps `wr_size` within the defined encodings and uses a short prescaler period, so that overflow intervals can be counted cycle by cycle.

// File: rtl/kcw_pkg.sv
package kcw_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_WORD = 2'b01,
    ACC_LONG = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;

  localparam int          SET_W     = 12;
  localparam int          ADDR_W    = 8;
  localparam int          DATA_W    = 32;
  localparam logic [ADDR_W-1:0] SET_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] CLR_ADDR = 8'h04;
  localparam logic [DATA_W-1:0] CLR_KEY  = 32'h0000_0055;
endpackage

// File: rtl/kcw_busdec.sv
module kcw_busdec
  import kcw_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              set_load,
  output logic [SET_W-1:0]  set_value,
  output logic              base_clear
);
  acc_size_e size_e;

  always_comb begin
    size_e     = acc_size_e'(wr_size);
    set_load   = wr_en && (wr_addr == SET_ADDR);
    set_value  = wr_data[SET_W-1:0];
    // Key must match in all 32 bits and arrive as a full longword.
    base_clear = wr_en && (wr_addr == CLR_ADDR) &&
                 (size_e == ACC_LONG) && (wr_data == CLR_KEY);
  end
endmodule

// File: rtl/kcw_prescaler.sv
module kcw_prescaler #(
  parameter int BASE_PERIOD = 262144,
  parameter int BASE_W      = $clog2(BASE_PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  output logic [BASE_W-1:0] count,
  output logic              tick
);
  localparam logic [BASE_W-1:0] LAST   = BASE_W'(BASE_PERIOD - 1);
  localparam bit                IS_POW2 = ((BASE_PERIOD & (BASE_PERIOD - 1)) == 0);

  generate
    if (IS_POW2) begin : g_pow2
      always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else              count <= count + 1'b1;
      end
    end else begin : g_any
      always_ff @(posedge clk) begin
        if (rst || clear)       count <= '0;
        else if (count == LAST) count <= '0;
        else                    count <= count + 1'b1;
      end
    end
  endgenerate

  assign tick = (count == LAST) && !clear;
endmodule

// File: rtl/kcw_maincnt.sv
module kcw_maincnt #(
  parameter int SET_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SET_W-1:0] load_value,
  input  logic             tick,
  output logic [SET_W-1:0] count,
  output logic [SET_W-1:0] limit,
  output logic             ovf
);
  logic enabled;
  logic at_end;

  assign enabled = (limit != '0);
  assign at_end  = (count == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      limit <= '1;
      ovf   <= 1'b0;
    end else if (load) begin
      count <= '0;
      limit <= load_value;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (tick && enabled) begin
        if (at_end) begin
          count <= '0;
          ovf   <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kcw_top.sv
module kcw_top
  import kcw_pkg::*;
#(
  parameter int BASE_PERIOD = 262144,
  parameter int BASE_W      = $clog2(BASE_PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [31:0]       wr_data,
  output logic              ovf_pulse,
  output logic [BASE_W-1:0] base_count,
  output logic [11:0]       main_count,
  output logic [11:0]       setting
);
  logic             set_load;
  logic [SET_W-1:0] set_value;
  logic             base_clear;
  logic             base_tick;

  kcw_busdec u_dec (
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_size    (wr_size),
    .wr_data    (wr_data),
    .set_load   (set_load),
    .set_value  (set_value),
    .base_clear (base_clear)
  );

  kcw_prescaler #(.BASE_PERIOD(BASE_PERIOD), .BASE_W(BASE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clear (base_clear),
    .count (base_count),
    .tick  (base_tick)
  );

  kcw_maincnt #(.SET_W(SET_W)) u_main (
    .clk        (clk),
    .rst        (rst),
    .load       (set_load),
    .load_value (set_value),
    .tick       (base_tick),
    .count      (main_count),
    .limit      (setting),
    .ovf        (ovf_pulse)
  );
endmodule

// File: rtl/kcw_checker.sv
module kcw_checker #(
  parameter int BASE_PERIOD = 262144,
  parameter int BASE_W      = $clog2(BASE_PERIOD)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [7:0]        wr_addr,
  input logic [1:0]        wr_size,
  input logic [31:0]       wr_data,
  input logic              ovf_pulse,
  input logic [BASE_W-1:0] base_count,
  input logic [11:0]       main_count,
  input logic [11:0]       setting
);
  localparam logic [BASE_W-1:0] LAST = BASE_W'(BASE_PERIOD - 1);

  logic key_wr, set_wr, other_wr;
  assign set_wr   = wr_en && (wr_addr == 8'h00);
  assign key_wr   = wr_en && (wr_addr == 8'h04) && (wr_size == 2'b10) &&
                    (wr_data == 32'h0000_0055);
  assign other_wr = wr_en && !set_wr && !key_wr;

  initial a_period_min : assert (BASE_PERIOD >= 2);

  // R1
  a_r1_reset_state : assert property (@(posedge clk)
    rst |=> (base_count == '0 && main_count == '0 && setting == 12'hFFF && !ovf_pulse));

  // R2
  a_r2_base_range : assert property (@(posedge clk) disable iff (rst)
    base_count <= LAST);

  // R3
  a_r3_main_hold : assert property (@(posedge clk) disable iff (rst)
    (base_count != LAST && !set_wr) |=> $stable(main_count));

  // R4
  a_r4_key_clear : assert property (@(posedge clk) disable iff (rst)
    key_wr |=> (base_count == '0 && $stable(main_count) && !ovf_pulse));

  // R5
  a_r5_bad_write_ignored : assert property (@(posedge clk) disable iff (rst)
    other_wr |=> base_count == (($past(base_count) == LAST) ? '0
                                 : BASE_W'($past(base_count) + 1'b1)));

  // R6
  a_r6_set_clears : assert property (@(posedge clk) disable iff (rst)
    set_wr |=> (main_count == '0 && setting == $past(wr_data[11:0]) && !ovf_pulse));

  // R7
  a_r7_single_pulse : assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse);

  // R7
  a_r7_wrap_zero : assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> main_count == '0);

  // R9
  a_r9_disabled : assert property (@(posedge clk) disable iff (rst)
    (setting == '0) |-> (!ovf_pulse && main_count == '0));
endmodule

bind kcw_top kcw_checker #(.BASE_PERIOD(BASE_PERIOD), .BASE_W(BASE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_size    (wr_size),
  .wr_data    (wr_data),
  .ovf_pulse  (ovf_pulse),
  .base_count (base_count),
  .main_count (main_count),
  .setting    (setting)
);

// File: tb/kcw_top_test.sv
module kcw_top_test;
  localparam int P  = 8;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [1:0]    wr_size = '0;
  logic [31:0]   wr_data = '0;
  logic          ovf_pulse;
  logic [BW-1:0] base_count;
  logic [11:0]   main_count;
  logic [11:0]   setting;

  int checks = 0;
  int errors = 0;
  int ovf_seen = 0;
  int cycles = 0;
  bit done = 1'b0;

  kcw_top #(.BASE_PERIOD(P), .BASE_W(BW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .ovf_pulse(ovf_pulse), .base_count(base_count),
    .main_count(main_count), .setting(setting)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (ovf_pulse) ovf_seen++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [1:0] s, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_size = '0; wr_data = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ovf(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ovf_pulse && n < 1000);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    chk("R1 base", int'(base_count), 0);
    chk("R1 main", int'(main_count), 0);
    chk("R1 setting", int'(setting), 4095);
    chk("R1 ovf", int'(ovf_pulse), 0);
  endtask

  task automatic t_count;
    idle(5);
    chk("R2 base after 5", int'(base_count), 5);
    idle(3);
    chk("R2 base wrap", int'(base_count), 0);
    chk("R3 main step", int'(main_count), 1);
    idle(3);
    chk("R3 main hold", int'(main_count), 1);
  endtask

  task automatic t_key;
    wr(8'h04, 2'b10, 32'h55);
    chk("R4 base cleared", int'(base_count), 0);
    chk("R4 main kept", int'(main_count), 1);
  endtask

  task automatic t_bad;
    int b;
    b = int'(base_count);
    wr(8'h04, 2'b01, 32'h55);
    chk("R5 word size", int'(base_count), (b + 1) % P);
    b = int'(base_count);
    wr(8'h04, 2'b00, 32'h55);
    chk("R5 byte size", int'(base_count), (b + 1) % P);
    b = int'(base_count);
    wr(8'h04, 2'b10, 32'h56);
    chk("R5 wrong key", int'(base_count), (b + 1) % P);
    b = int'(base_count);
    wr(8'h04, 2'b10, 32'h0100_0055);
    chk("R5 upper bits", int'(base_count), (b + 1) % P);
    b = int'(base_count);
    wr(8'h08, 2'b10, 32'h55);
    chk("R5 other addr", int'(base_count), (b + 1) % P);
    chk("R5 setting kept", int'(setting), 4095);
  endtask

  task automatic t_set;
    wr(8'h00, 2'b01, 32'hABC0_0003);
    chk("R6 main cleared", int'(main_count), 0);
    chk("R6 setting", int'(setting), 3);
  endtask

  task automatic t_ovf;
    int n;
    wr(8'h04, 2'b10, 32'h55);
    wr(8'h00, 2'b10, 32'h3);
    wait_ovf(n);
    chk("R7 first interval", n, 3 * P - 1);
    chk("R7 main wrapped", int'(main_count), 0);
    idle(1);
    chk("R7 single pulse", int'(ovf_pulse), 0);
    wait_ovf(n);
    chk("R7 period", n + 1, 3 * P);
  endtask

  task automatic t_min;
    int n;
    wr(8'h04, 2'b10, 32'h55);
    wr(8'h00, 2'b00, 32'h1);
    wait_ovf(n);
    chk("R8 min interval", n, P - 1);
  endtask

  task automatic t_off;
    int s;
    wr(8'h00, 2'b10, 32'h0);
    s = ovf_seen;
    idle(5 * P);
    chk("R9 no ovf", ovf_seen - s, 0);
    chk("R9 main zero", int'(main_count), 0);
  endtask

  task automatic t_refresh;
    int s;
    wr(8'h04, 2'b10, 32'h55);
    wr(8'h00, 2'b10, 32'h2);
    s = ovf_seen;
    for (int i = 0; i < 6; i++) begin
      idle(P - 3);
      wr(8'h04, 2'b10, 32'h55);
    end
    chk("R10 no ovf", ovf_seen - s, 0);
    chk("R10 main held", int'(main_count), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_key();
    t_bad();
    t_set();
    t_ovf();
    t_min();
    t_off();
    t_refresh();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule